// File: doc/BRIEF.md
# Multi-Writer Register File with Pending-Write Queue

This block is a small register file whose storage array can take only one write per clock, yet it accepts a write request from each of several writers in the same cycle. Every writer drives a valid flag, a register index and a data word. When several writers are active together, one write goes into the array at once. The other writes wait in a pending-write queue that empties into the array one entry at a time, in cycles where no writer is active.

Several read ports return data with no clock delay. A read looks in the pending queue first and returns the youngest queued value for its index. If the queue holds no value for that index, the read returns the array contents. A queued entry becomes stale when a later direct write targets the same index. Such an entry is marked dead, so that draining it never overwrites the newer value.

The block suits designs with bursty multi-source updates and enough idle cycles to absorb them. The `wr_ready` output tells the writers when the queue could not take a full burst.

Top module: `mwrf_top`

## Requirements
- R1: When exactly one writer is active and accepted, its data goes straight into the array, the queue occupancy stays the same, and a read of that index returns the data from the next cycle on.
- R2: When several writers are active and accepted, the lowest-numbered writer (bit 0 of `wr_vld` is writer 0) writes the array directly. The other writers are appended to the queue in ascending writer order, and every written value is readable from the next cycle.
- R3: In a cycle with no accepted write and a non-empty queue, exactly one entry leaves the queue in first-in first-out order and is written into the array. The queue occupancy then drops by one.
- R4: A read of an index that has queued entries returns the value of the most recently queued entry for that index. This holds even after older entries for that index have drained.
- R5: Read ports are combinational: `rd_data` follows a change of `rd_idx` with no clock edge.
- R6: `wr_ready` is low while the free queue slots number fewer than the writer count minus one. Writes presented while `wr_ready` is low have no effect on the array or the queue, and that cycle counts as idle for draining.
- R7: A direct array write to an index supersedes any older queued entries for that index. Reads return the direct value, and a later drain of the superseded entries leaves the array unchanged.
- R8: Synchronous active-high reset empties the queue, so `wr_ready` is high after reset. Array contents are not reset.
- R9: Each read port is served independently: two ports reading different indices in the same cycle each get their own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties the queue |
| wr_vld | input | NUM_WR | Per-writer request flag, bit w for writer w |
| wr_idx | input | NUM_WR*IDX_W | Writer indices, writer w at bits [w*IDX_W +: IDX_W] |
| wr_data | input | NUM_WR*DATA_W | Writer data, writer w at bits [w*DATA_W +: DATA_W] |
| wr_ready | output | 1 | High when a full burst of writes can be accepted |
| rd_idx | input | NUM_RD*IDX_W | Read indices, port p at bits [p*IDX_W +: IDX_W] |
| rd_data | output | NUM_RD*DATA_W | Read data, port p at bits [p*DATA_W +: DATA_W] |

## Verification
The main function is tried with four kinds of write pattern: a lone writer, all writers together, a subset that leaves writer 0 idle, and a run of idle cycles after queued bursts. The lone-writer case separates the direct path from the queue path. The subset case checks that priority goes to the lowest active writer and not simply to writer 0. The idle run shows whether draining keeps the youngest value visible, so that an older queued value never surfaces on a read. A burst sequence fills the queue until `wr_ready` falls, which exercises the ignore rule and the point at which ready returns. A direct write over a queued index tells dead-entry marking apart from a plain drain.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;

  // Source of the single array write in a cycle
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_WRITER = 2'd1,
    SRC_QUEUE  = 2'd2
  } mwrf_src_e;

endpackage

// File: rtl/mwrf_array.sv
module mwrf_array #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8,
  parameter int NUM_RD = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [IDX_W-1:0]         waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_RD*IDX_W-1:0]  raddr,
  output logic [NUM_RD*DATA_W-1:0] rdata
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [ENTRIES];

  // Single write port, no reset on storage
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata[p*DATA_W +: DATA_W] = mem[raddr[p*IDX_W +: IDX_W]];
  end

endmodule

// File: rtl/mwrf_wr_sel.sv
module mwrf_wr_sel #(
  parameter int NUM_WR = 3,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8,
  localparam int ENQ_N  = NUM_WR - 1,
  localparam int ENQ_CW = $clog2(NUM_WR)
) (
  input  logic [NUM_WR-1:0]        wr_vld,
  input  logic [NUM_WR*IDX_W-1:0]  wr_idx,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  output logic                     dir_vld,
  output logic [IDX_W-1:0]         dir_idx,
  output logic [DATA_W-1:0]        dir_data,
  output logic [ENQ_CW-1:0]        enq_cnt,
  output logic [ENQ_N*IDX_W-1:0]   enq_idx,
  output logic [ENQ_N*DATA_W-1:0]  enq_data
);

  logic [IDX_W-1:0]  enq_idx_a  [ENQ_N];
  logic [DATA_W-1:0] enq_data_a [ENQ_N];

  // Lowest active writer goes direct; the rest are packed in ascending order
  always_comb begin
    int n;
    n        = 0;
    dir_vld  = 1'b0;
    dir_idx  = '0;
    dir_data = '0;
    for (int j = 0; j < ENQ_N; j++) begin
      enq_idx_a[j]  = '0;
      enq_data_a[j] = '0;
    end
    for (int w = 0; w < NUM_WR; w++) begin
      if (wr_vld[w]) begin
        if (!dir_vld) begin
          dir_vld  = 1'b1;
          dir_idx  = wr_idx[w*IDX_W +: IDX_W];
          dir_data = wr_data[w*DATA_W +: DATA_W];
        end else begin
          if (n < ENQ_N) begin
            enq_idx_a[n]  = wr_idx[w*IDX_W +: IDX_W];
            enq_data_a[n] = wr_data[w*DATA_W +: DATA_W];
          end
          n++;
        end
      end
    end
    enq_cnt = ENQ_CW'(n);
  end

  for (genvar j = 0; j < ENQ_N; j++) begin : g_pack
    assign enq_idx[j*IDX_W +: IDX_W]    = enq_idx_a[j];
    assign enq_data[j*DATA_W +: DATA_W] = enq_data_a[j];
  end

endmodule

// File: rtl/mwrf_pend_q.sv
module mwrf_pend_q #(
  parameter int NUM_WR  = 3,
  parameter int NUM_RD  = 2,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 8,
  parameter int Q_DEPTH = 8,
  localparam int ENQ_N  = NUM_WR - 1,
  localparam int ENQ_CW = $clog2(NUM_WR),
  localparam int PTR_W  = $clog2(Q_DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     kill_vld,
  input  logic [IDX_W-1:0]         kill_idx,
  input  logic [ENQ_CW-1:0]        enq_cnt,
  input  logic [ENQ_N*IDX_W-1:0]   enq_idx,
  input  logic [ENQ_N*DATA_W-1:0]  enq_data,
  input  logic                     pop,
  output logic [CNT_W-1:0]         count,
  output logic                     head_vld,
  output logic [IDX_W-1:0]         head_idx,
  output logic [DATA_W-1:0]        head_data,
  input  logic [NUM_RD*IDX_W-1:0]  rd_idx,
  output logic [NUM_RD-1:0]        fwd_hit,
  output logic [NUM_RD*DATA_W-1:0] fwd_data
);

  logic              slot_vld  [Q_DEPTH];
  logic [IDX_W-1:0]  slot_idx  [Q_DEPTH];
  logic [DATA_W-1:0] slot_data [Q_DEPTH];
  logic [PTR_W-1:0]  head;
  logic [PTR_W-1:0]  wr_slot   [ENQ_N];

  always_comb begin
    for (int j = 0; j < ENQ_N; j++)
      wr_slot[j] = PTR_W'(int'(head) + int'(count) + j);
  end

  // Live flags: reset clears, a direct write kills stale entries, append sets
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < Q_DEPTH; s++) slot_vld[s] <= 1'b0;
    end else begin
      if (kill_vld) begin
        for (int s = 0; s < Q_DEPTH; s++)
          if (slot_idx[s] == kill_idx) slot_vld[s] <= 1'b0;
      end
      for (int j = 0; j < ENQ_N; j++)
        if (j < int'(enq_cnt)) slot_vld[wr_slot[j]] <= 1'b1;
    end
  end

  // Payload storage, no reset
  always_ff @(posedge clk) begin
    for (int j = 0; j < ENQ_N; j++) begin
      if (j < int'(enq_cnt)) begin
        slot_idx[wr_slot[j]]  <= enq_idx[j*IDX_W +: IDX_W];
        slot_data[wr_slot[j]] <= enq_data[j*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (pop) head <= head + PTR_W'(1);
      count <= count + CNT_W'(enq_cnt) - CNT_W'(pop);
    end
  end

  assign head_vld  = slot_vld[head];
  assign head_idx  = slot_idx[head];
  assign head_data = slot_data[head];

  // Youngest live entry per read index wins (scan oldest to youngest)
  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      fwd_hit[p] = 1'b0;
      fwd_data[p*DATA_W +: DATA_W] = '0;
      for (int k = 0; k < Q_DEPTH; k++) begin
        if (CNT_W'(k) < count
            && slot_vld[PTR_W'(int'(head) + k)]
            && slot_idx[PTR_W'(int'(head) + k)] == rd_idx[p*IDX_W +: IDX_W]) begin
          fwd_hit[p] = 1'b1;
          fwd_data[p*DATA_W +: DATA_W] = slot_data[PTR_W'(int'(head) + k)];
        end
      end
    end
  end

  // R6: occupancy never exceeds the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(Q_DEPTH));

  // R3: a drain only happens on a non-empty queue
  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);

  // R6: an append never goes past the free slots
  a_r6_room_for_enq: assert property (@(posedge clk) disable iff (rst)
    (enq_cnt != '0) |-> (int'(count) + int'(enq_cnt) <= Q_DEPTH));

endmodule

// File: rtl/mwrf_top.sv
module mwrf_top #(
  parameter int NUM_WR  = 3,
  parameter int NUM_RD  = 2,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 8,
  parameter int Q_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_WR-1:0]        wr_vld,
  input  logic [NUM_WR*IDX_W-1:0]  wr_idx,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  output logic                     wr_ready,
  input  logic [NUM_RD*IDX_W-1:0]  rd_idx,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);
  import mwrf_pkg::*;

  localparam int ENQ_N  = NUM_WR - 1;
  localparam int ENQ_CW = $clog2(NUM_WR);
  localparam int CNT_W  = $clog2(Q_DEPTH) + 1;
  localparam int READY_MAX = Q_DEPTH - ENQ_N;

  logic [NUM_WR-1:0]        acc_vld;
  logic                     dir_vld;
  logic [IDX_W-1:0]         dir_idx;
  logic [DATA_W-1:0]        dir_data;
  logic [ENQ_CW-1:0]        enq_cnt;
  logic [ENQ_N*IDX_W-1:0]   enq_idx;
  logic [ENQ_N*DATA_W-1:0]  enq_data;
  logic [CNT_W-1:0]         count;
  logic                     head_vld;
  logic [IDX_W-1:0]         head_idx;
  logic [DATA_W-1:0]        head_data;
  logic                     pop;
  logic [NUM_RD-1:0]        fwd_hit;
  logic [NUM_RD*DATA_W-1:0] fwd_data;
  logic [NUM_RD*DATA_W-1:0] arr_data;
  mwrf_src_e                src;
  logic                     arr_we;
  logic [IDX_W-1:0]         arr_waddr;
  logic [DATA_W-1:0]        arr_wdata;

  assign wr_ready = (count <= CNT_W'(READY_MAX));
  assign acc_vld  = wr_vld & {NUM_WR{wr_ready}};
  assign pop      = (acc_vld == '0) && (count != '0);

  mwrf_wr_sel #(
    .NUM_WR(NUM_WR), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_sel (
    .wr_vld  (acc_vld),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .dir_vld (dir_vld),
    .dir_idx (dir_idx),
    .dir_data(dir_data),
    .enq_cnt (enq_cnt),
    .enq_idx (enq_idx),
    .enq_data(enq_data)
  );

  mwrf_pend_q #(
    .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .IDX_W(IDX_W),
    .DATA_W(DATA_W), .Q_DEPTH(Q_DEPTH)
  ) u_q (
    .clk      (clk),
    .rst      (rst),
    .kill_vld (dir_vld),
    .kill_idx (dir_idx),
    .enq_cnt  (enq_cnt),
    .enq_idx  (enq_idx),
    .enq_data (enq_data),
    .pop      (pop),
    .count    (count),
    .head_vld (head_vld),
    .head_idx (head_idx),
    .head_data(head_data),
    .rd_idx   (rd_idx),
    .fwd_hit  (fwd_hit),
    .fwd_data (fwd_data)
  );

  always_comb begin
    if (dir_vld)               src = SRC_WRITER;
    else if (pop && head_vld)  src = SRC_QUEUE;
    else                       src = SRC_NONE;
  end

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = '0;
    arr_wdata = '0;
    unique case (src)
      SRC_WRITER: begin arr_we = 1'b1; arr_waddr = dir_idx;  arr_wdata = dir_data;  end
      SRC_QUEUE:  begin arr_we = 1'b1; arr_waddr = head_idx; arr_wdata = head_data; end
      default:    ;
    endcase
  end

  mwrf_array #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)
  ) u_arr (
    .clk  (clk),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(arr_wdata),
    .raddr(rd_idx),
    .rdata(arr_data)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rmux
    assign rd_data[p*DATA_W +: DATA_W] = fwd_hit[p] ? fwd_data[p*DATA_W +: DATA_W]
                                                    : arr_data[p*DATA_W +: DATA_W];
  end

  // R1: a lone accepted writer leaves the queue occupancy unchanged
  a_r1_lone_write_no_enq: assert property (@(posedge clk) disable iff (rst)
    ($countones(acc_vld) == 1) |=> count == $past(count));

  // R2: k accepted writers grow the queue by k-1
  a_r2_burst_grows_queue: assert property (@(posedge clk) disable iff (rst)
    ($countones(acc_vld) > 1)
      |=> int'(count) == int'($past(count)) + $countones($past(acc_vld)) - 1);

  // R3: an idle cycle with pending work drains exactly one entry
  a_r3_idle_drains_one: assert property (@(posedge clk) disable iff (rst)
    (acc_vld == '0 && count != '0) |=> int'(count) == int'($past(count)) - 1);

  // R6: while not ready the queue cannot grow
  a_r6_not_ready_no_growth: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |=> count <= $past(count));

  // R1: the direct path and a drain never share a cycle
  a_r1_one_array_write: assert property (@(posedge clk) disable iff (rst)
    !(dir_vld && pop));

endmodule

// File: tb/mwrf_top_tb_top.sv
`timescale 1ns/1ps
module mwrf_top_tb_top;

  localparam int NUM_WR  = 3;
  localparam int NUM_RD  = 2;
  localparam int IDX_W   = 4;
  localparam int DATA_W  = 8;
  localparam int Q_DEPTH = 8;
  localparam int NVEC    = 9;

  // vld[62:60] i0 i1 i2 [59:48] d0 d1 d2 [47:24] c0 c1 [23:16] e0 e1 [15:0]
  localparam logic [62:0] VEC [NVEC] = '{
    {3'b001, 4'd1, 4'd0, 4'd0, 8'h11, 8'h00, 8'h00, 4'd1, 4'd1, 8'h11, 8'h11},
    {3'b111, 4'd2, 4'd3, 4'd4, 8'h22, 8'h33, 8'h44, 4'd3, 4'd4, 8'h33, 8'h44},
    {3'b110, 4'd0, 4'd5, 4'd3, 8'h00, 8'h55, 8'h3A, 4'd3, 4'd5, 8'h3A, 8'h55},
    {3'b000, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 4'd3, 4'd2, 8'h3A, 8'h22},
    {3'b000, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 4'd4, 4'd1, 8'h44, 8'h11},
    {3'b000, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 4'd3, 4'd3, 8'h3A, 8'h3A},
    {3'b011, 4'd6, 4'd7, 4'd0, 8'h66, 8'h77, 8'h00, 4'd6, 4'd7, 8'h66, 8'h77},
    {3'b001, 4'd7, 4'd0, 4'd0, 8'h70, 8'h00, 8'h00, 4'd7, 4'd6, 8'h70, 8'h66},
    {3'b000, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 4'd7, 4'd7, 8'h70, 8'h70}
  };

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [NUM_WR-1:0]        wr_vld = '0;
  logic [NUM_WR*IDX_W-1:0]  wr_idx = '0;
  logic [NUM_WR*DATA_W-1:0] wr_data = '0;
  logic                     wr_ready;
  logic [NUM_RD*IDX_W-1:0]  rd_idx = '0;
  logic [NUM_RD*DATA_W-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mwrf_top #(
    .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .IDX_W(IDX_W),
    .DATA_W(DATA_W), .Q_DEPTH(Q_DEPTH)
  ) dut_i (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (wr_vld),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_ready(wr_ready),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  // Present writes at a falling edge, commit at the rising edge, return at the next falling edge
  task automatic do_cycle(input logic [2:0] v,
                          input logic [3:0] i0, input logic [3:0] i1, input logic [3:0] i2,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    wr_vld  = v;
    wr_idx  = {i2, i1, i0};
    wr_data = {d2, d1, d0};
    @(posedge clk);
    @(negedge clk);
    wr_vld  = '0;
  endtask

  task automatic chk_rd(input int port, input logic [3:0] idx, input logic [7:0] exp,
                        input string tag);
    logic [7:0] got;
    rd_idx[port*IDX_W +: IDX_W] = idx;
    #1;
    got = rd_data[port*DATA_W +: DATA_W];
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: port %0d idx %0d got %h expected %h", tag, port, idx, got, exp);
    end
  endtask

  task automatic chk_ready(input logic exp, input string tag);
    n_chk++;
    if (wr_ready !== exp) begin
      n_fail++;
      $display("FAIL %s: wr_ready got %b expected %b", tag, wr_ready, exp);
    end
  endtask

  function automatic string vec_tag(input int k);
    case (k)
      0:       return "R1";
      1, 6:    return "R2";
      7, 8:    return "R7";
      default: return "R4";
    endcase
  endfunction

  // Four full bursts: writer 0 hits idx 1, writers 1 and 2 queue idx 8..15
  task automatic fill_queue(input string tag);
    for (int k = 0; k < 4; k++) begin
      do_cycle(3'b111, 4'd1, 4'(8 + 2*k), 4'(9 + 2*k),
               8'(8'h10 + k), 8'(8'h88 + 2*k), 8'(8'h89 + 2*k));
      chk_ready(k < 3, tag);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_ready(1'b1, "R8 reset state");

    // Table walk: R1, R2, R4, R7 with both ports (R9)
    for (int k = 0; k < NVEC; k++) begin
      do_cycle(VEC[k][62:60], VEC[k][59:56], VEC[k][55:52], VEC[k][51:48],
               VEC[k][47:40], VEC[k][39:32], VEC[k][31:24]);
      chk_rd(0, VEC[k][23:20], VEC[k][15:8], vec_tag(k));
      chk_rd(1, VEC[k][19:16], VEC[k][7:0],  vec_tag(k));
    end

    // R9: two ports, two different indices, same instant
    rd_idx = {4'd5, 4'd2};
    #1;
    n_chk++;
    if (rd_data !== {8'h55, 8'h22}) begin
      n_fail++;
      $display("FAIL R9: got %h expected %h", rd_data, {8'h55, 8'h22});
    end

    // R5: read follows index change with no clock edge
    chk_rd(0, 4'd1, 8'h11, "R5");
    chk_rd(0, 4'd4, 8'h44, "R5");

    // R6 / R3: fill until not ready, then an ignored burst, then drain
    fill_queue("R6 fill");
    do_cycle(3'b111, 4'd2, 4'd3, 4'd4, 8'hEE, 8'hEE, 8'hEE);
    chk_ready(1'b0, "R6 still low after one drain");
    chk_rd(0, 4'd2, 8'h22, "R6 ignored write");
    chk_rd(1, 4'd3, 8'h3A, "R6 ignored write");
    chk_rd(0, 4'd4, 8'h44, "R6 ignored write");
    do_cycle(3'b000, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00);
    chk_ready(1'b1, "R3 second drain frees room");
    repeat (6) do_cycle(3'b000, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00);
    for (int i = 8; i < 16; i++)
      chk_rd(i % 2, 4'(i), 8'(8'h80 + i), "R3 drained value");
    chk_rd(0, 4'd1, 8'h13, "R1 last direct write");

    // R8: reset empties a full queue
    fill_queue("R8 refill");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_ready(1'b1, "R8 queue emptied");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule